// File: doc/BRIEF.md
# Command Stream Packet Header Parser

This block sits on a stream of 32-bit command words arriving over a valid/ready handshake and cuts the stream into packets. A packet is one header word followed by as many payload words as the header's count says. The parser reads the packet type from the top nibble of each header, pulls out the register index or opcode and the payload length, and checks the odd-parity bits that the newer header formats carry. The legacy formats store the count minus one; the newer ones store it as is. It then passes each payload word straight through with a tag. The tag is the register address for register-write packets, or the opcode for opcode packets. Each word also carries its position within the payload.

No-op headers are swallowed and produce no output. A header with an unknown type code or a bad parity bit sets a sticky error flag. While that flag is up every incoming word is discarded. Once software pulses the clear input, the word after the clear is taken as a fresh header. A done strobe marks the end of each packet. It rides with the last payload word, or with the header itself when the payload is empty.

Top module: `cmd_pkt_parser`

## Requirements
- R1: The type code is header bits [31:28]. Code 0x0 selects the legacy register format and 0x4 the parity-checked register format. Code 0x7 selects the parity-checked opcode format. Codes 0x8 to 0xB select the no-op and 0xC to 0xF the legacy opcode format. Codes 0x1, 0x2, 0x3, 0x5 and 0x6 set hdr_err on the cycle after the header is accepted.
- R2: Legacy register header: the register index is bits [14:0] and the payload length is bits [27:16] plus one. Payload word k is tagged with index+k and out_is_reg=1.
- R3: Legacy opcode header: the opcode is bits [15:8] and the payload length is bits [29:16] plus one. Every payload word is tagged with the opcode and out_is_reg=0.
- R4: A no-op header is consumed with in_ready high. It produces neither out_valid nor pkt_done, and the word after it is decoded as a header.
- R5: Parity-checked register header: the length is bits [6:0] (0 to 127), with its parity in bit 7. The 18-bit register index is bits [25:8], with its parity in bit 27. Payload words are tagged index+k.
- R6: Parity-checked opcode header: the length is bits [14:0], with its parity in bit 15. The 7-bit opcode is bits [22:16], with its parity in bit 23.
- R7: Each parity bit is odd parity over its field: the bit is 1 exactly when the field holds an even number of ones. Any mismatch sets hdr_err.
- R8: hdr_err is sticky until err_clear. While it is set, out_valid stays 0 and every offered word is consumed and dropped. After the clear, the next word is decoded as a header.
- R9: out_index counts payload words from 0 and out_last marks the final one. pkt_done pulses with the last payload transfer, or in the header's own cycle when the length is 0.
- R10: While a payload word is offered and out_ready is low, in_ready is low and the parser's position does not advance, so no word is lost.
- R11: After reset, hdr_err=0, out_valid=0 and in_ready=1, and the first word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word taken this cycle |
| in_word | input | 32 | Command word |
| err_clear | input | 1 | Clears the sticky header error |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Downstream takes the payload word |
| out_data | output | 32 | Payload word |
| out_is_reg | output | 1 | 1: tag is a register address, 0: tag is an opcode |
| out_tag | output | 18 | Register address or opcode |
| out_index | output | 15 | Position of the word within its payload |
| out_last | output | 1 | Final payload word of the packet |
| pkt_done | output | 1 | Packet completes this cycle |
| hdr_err | output | 1 | Sticky bad-header flag |

## Verification
Two things can land in one cycle: accepting an empty-payload header and raising pkt_done from it, or the final payload transfer raising pkt_done. The bench feeds back-to-back packets with no idle cycle, so an empty header directly follows the final word of the previous packet. It checks that each done pulse comes in exactly the right cycle, that only one comes per packet, and that it carries the right tag. The bench also sends a legal header in the cycle right after an erroring one. A stalled final word is held against out_ready. In both cases the bench checks that the word is dropped or held, never forwarded twice.

// File: rtl/cmd_pkt_pkg.sv
// Shared types and helpers for the command packet parser.
// Assumes 32-bit command words; header field positions are fixed by format.
package cmd_pkt_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 18;
    localparam int CNT_W  = 16;
    localparam int IDX_W  = 15;

    typedef enum logic [1:0] {
        KIND_NOP = 2'd0,
        KIND_REG = 2'd1,
        KIND_OPC = 2'd2,
        KIND_BAD = 2'd3
    } pkt_kind_t;

    // Odd-parity check: field ones plus the parity bit must be odd.
    function automatic logic parity_ok(input logic [WORD_W-1:0] field, input logic pbit);
        return (^field) ^ pbit;
    endfunction

endpackage

// File: rtl/cmd_hdr_decode.sv
// Combinational header decoder: classifies a word by its type nibble and
// extracts target (register index or opcode) and payload length.
// Assumes the caller presents the word only when a header is expected.
module cmd_hdr_decode
    import cmd_pkt_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int RW  = REG_W,
    parameter int CW  = CNT_W
) (
    input  logic [W-1:0]  word,
    output pkt_kind_t     kind,
    output logic [RW-1:0] target,
    output logic [CW-1:0] count
);

    localparam int L0_CW = 12;
    localparam int L3_CW = 14;

    logic par4, par7;

    // Parity verdicts for the two checked formats.
    always_comb begin
        par4 = parity_ok(W'(word[6:0]), word[7]) &&
               parity_ok(W'(word[25:8]), word[27]);
        par7 = parity_ok(W'(word[14:0]), word[15]) &&
               parity_ok(W'(word[22:16]), word[23]);
    end

    // Type selection and field extraction.
    always_comb begin
        kind   = KIND_BAD;
        target = '0;
        count  = '0;
        unique casez (word[31:28])
            4'b0000: begin
                kind   = KIND_REG;
                target = RW'(word[14:0]);
                count  = CW'(word[16 +: L0_CW]) + CW'(1);
            end
            4'b10??: begin
                kind = KIND_NOP;
            end
            4'b11??: begin
                kind   = KIND_OPC;
                target = RW'(word[15:8]);
                count  = CW'(word[16 +: L3_CW]) + CW'(1);
            end
            4'b0100: begin
                kind   = par4 ? KIND_REG : KIND_BAD;
                target = RW'(word[25:8]);
                count  = CW'(word[6:0]);
            end
            4'b0111: begin
                kind   = par7 ? KIND_OPC : KIND_BAD;
                target = RW'(word[22:16]);
                count  = CW'(word[14:0]);
            end
            default: kind = KIND_BAD;
        endcase
    end

endmodule

// File: rtl/cmd_pay_seq.sv
// Payload sequencer: holds the open packet's state, counts payload words,
// forms tags, and owns the sticky error flag.
// Assumes decoded header fields are valid whenever a header is expected.
module cmd_pay_seq
    import cmd_pkt_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          err_clear,
    input  pkt_kind_t     dec_kind,
    input  logic [RW-1:0] dec_target,
    input  logic [CW-1:0] dec_count,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_is_reg,
    output logic [RW-1:0] out_tag,
    output logic [IW-1:0] out_index,
    output logic          out_last,
    output logic          pkt_done,
    output logic          hdr_err
);

    logic          busy;
    logic [CW-1:0] remain;
    logic [IW-1:0] idx;
    logic [RW-1:0] tgt;
    logic          is_reg;
    logic          accept;
    logic          hdr_take;
    logic          empty_done;

    // Handshake and output strobes.
    always_comb begin
        in_ready   = hdr_err || !busy || out_ready;
        accept     = in_valid && in_ready;
        hdr_take   = accept && !hdr_err && !busy;
        out_valid  = busy && !hdr_err && in_valid;
        out_last   = (remain == CW'(1));
        empty_done = hdr_take && (dec_kind == KIND_REG || dec_kind == KIND_OPC) &&
                     (dec_count == '0);
        pkt_done   = empty_done || (out_valid && out_ready && out_last);
    end

    // Tag and position presented with each payload word.
    always_comb begin
        out_is_reg = is_reg;
        out_index  = idx;
        out_tag    = is_reg ? tgt + RW'(idx) : tgt;
    end

    // Packet state, counters and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            remain  <= '0;
            idx     <= '0;
            tgt     <= '0;
            is_reg  <= 1'b0;
            hdr_err <= 1'b0;
        end else if (hdr_err) begin
            busy <= 1'b0;
            if (err_clear) hdr_err <= 1'b0;
        end else if (hdr_take) begin
            if (dec_kind == KIND_BAD) begin
                hdr_err <= 1'b1;
            end else if (dec_kind != KIND_NOP && dec_count != '0) begin
                busy   <= 1'b1;
                remain <= dec_count;
                idx    <= '0;
                tgt    <= dec_target;
                is_reg <= (dec_kind == KIND_REG);
            end
        end else if (accept && busy) begin
            remain <= remain - CW'(1);
            idx    <= idx + IW'(1);
            if (out_last) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_pkt_parser.sv
// Top of the command packet parser: decoder plus payload sequencer.
// Payload words pass through combinationally; only packet state is registered.
module cmd_pkt_parser
    import cmd_pkt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                err_clear,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_is_reg,
    output logic [REG_W-1:0]    out_tag,
    output logic [IDX_W-1:0]    out_index,
    output logic                out_last,
    output logic                pkt_done,
    output logic                hdr_err
);

    pkt_kind_t          dec_kind;
    logic [REG_W-1:0]   dec_target;
    logic [CNT_W-1:0]   dec_count;

    assign out_data = in_word;

    cmd_hdr_decode #(.W(WORD_W), .RW(REG_W), .CW(CNT_W)) u_dec (
        .word   (in_word),
        .kind   (dec_kind),
        .target (dec_target),
        .count  (dec_count)
    );

    cmd_pay_seq #(.RW(REG_W), .CW(CNT_W), .IW(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .err_clear  (err_clear),
        .dec_kind   (dec_kind),
        .dec_target (dec_target),
        .dec_count  (dec_count),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_is_reg (out_is_reg),
        .out_tag    (out_tag),
        .out_index  (out_index),
        .out_last   (out_last),
        .pkt_done   (pkt_done),
        .hdr_err    (hdr_err)
    );

endmodule

// File: rtl/cmd_pkt_parser_chk.sv
// Checker for the parser's port-level protocol; bound to the top below.
module cmd_pkt_parser_chk
    import cmd_pkt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             err_clear,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_index,
    input logic             out_last,
    input logic             pkt_done,
    input logic             hdr_err
);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err && !err_clear |=> hdr_err);

    p_quiet_in_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !out_valid && in_ready);

    p_err_from_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_err ##1 hdr_err |-> $past(in_valid && in_ready));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_hold_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_index));

    p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |-> pkt_done);

    p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_index == $past(out_index) + IDX_W'(1));

endmodule

bind cmd_pkt_parser cmd_pkt_parser_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .err_clear (err_clear),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_index (out_index),
    .out_last  (out_last),
    .pkt_done  (pkt_done),
    .hdr_err   (hdr_err)
);

// File: tb/tb_cmd_pkt_parser.sv
module tb_cmd_pkt_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        err_clear = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_is_reg;
    logic [17:0] out_tag;
    logic [14:0] out_index;
    logic        out_last;
    logic        pkt_done;
    logic        hdr_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmd_pkt_parser dut (.*);

    typedef struct packed {
        logic [31:0] word;
        logic        ov;
        logic        isreg;
        logic [17:0] tag;
        logic [14:0] idx;
        logic        last;
        logic        done;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{32'h00010123, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b0}, // R2 hdr reg 0x123 len 2
        '{32'hAAAA0001, 1'b1, 1'b1, 18'h123,   15'd0, 1'b0, 1'b0},
        '{32'hBBBB0002, 1'b1, 1'b1, 18'h124,   15'd1, 1'b1, 1'b1},
        '{32'h80000000, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b0}, // R4 no-op
        '{32'hC0005A00, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b0}, // R3 opc 0x5A len 1
        '{32'h11111111, 1'b1, 1'b0, 18'h5A,    15'd0, 1'b1, 1'b1},
        '{32'h40001002, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b0}, // R5 reg 0x10 len 2
        '{32'h00000001, 1'b1, 1'b1, 18'h10,    15'd0, 1'b0, 1'b0},
        '{32'h00000002, 1'b1, 1'b1, 18'h11,    15'd1, 1'b1, 1'b1},
        '{32'h40001080, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b1}, // R9 empty reg hdr
        '{32'h70A10001, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b0}, // R6 opc 0x21 len 1
        '{32'h0000CAFE, 1'b1, 1'b0, 18'h21,    15'd0, 1'b1, 1'b1},
        '{32'h70018000, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b1}, // R9 empty opc hdr
        '{32'h48000383, 1'b0, 1'b0, 18'h0,     15'd0, 1'b0, 1'b0}, // R7 both parities 1
        '{32'h00000005, 1'b1, 1'b1, 18'h3,     15'd0, 1'b0, 1'b0},
        '{32'h00000006, 1'b1, 1'b1, 18'h4,     15'd1, 1'b0, 1'b0},
        '{32'h00000007, 1'b1, 1'b1, 18'h5,     15'd2, 1'b1, 1'b1}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive for one cycle; outputs are sampled 2 ns before the next rising edge.
    task automatic drive(input logic v, input logic [31:0] w, input logic ordy, input logic clr);
        @(negedge clk);
        in_valid  = v;
        in_word   = w;
        out_ready = ordy;
        err_clear = clr;
        #8;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        drive(1'b0, '0, 1'b1, 1'b0);
        // R11 reset state
        check("R11", "hdr_err", 32'(hdr_err), 0);
        check("R11", "out_valid", 32'(out_valid), 0);
        check("R11", "in_ready", 32'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table, back to back
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i].word, 1'b1, 1'b0);
            check("R9", $sformatf("vec%0d done", i), 32'(pkt_done), 32'(VEC[i].done));
            check("R2", $sformatf("vec%0d valid", i), 32'(out_valid), 32'(VEC[i].ov));
            check("R4", $sformatf("vec%0d ready", i), 32'(in_ready), 1);
            if (VEC[i].ov) begin
                check("R3", $sformatf("vec%0d tag", i), 32'(out_tag), 32'(VEC[i].tag));
                check("R5", $sformatf("vec%0d isreg", i), 32'(out_is_reg), 32'(VEC[i].isreg));
                check("R9", $sformatf("vec%0d idx", i), 32'(out_index), 32'(VEC[i].idx));
                check("R9", $sformatf("vec%0d last", i), 32'(out_last), 32'(VEC[i].last));
                check("R6", $sformatf("vec%0d data", i), out_data, VEC[i].word);
            end
            check("R7", $sformatf("vec%0d err", i), 32'(hdr_err), 0);
        end

        // R1 illegal type code 0x1, then a legal-looking header is dropped
        drive(1'b1, 32'h10000000, 1'b1, 1'b0);
        drive(1'b1, 32'h40001080, 1'b1, 1'b0);
        check("R1", "err after illegal", 32'(hdr_err), 1);
        check("R8", "dropped hdr no done", 32'(pkt_done), 0);
        drive(1'b1, 32'h00000009, 1'b1, 1'b0);
        check("R8", "dropped word valid", 32'(out_valid), 0);
        check("R8", "ready in err", 32'(in_ready), 1);
        drive(1'b0, '0, 1'b1, 1'b1);
        drive(1'b1, 32'hC0005A00, 1'b1, 1'b0);
        check("R8", "err cleared", 32'(hdr_err), 0);
        drive(1'b1, 32'h12345678, 1'b1, 1'b0);
        check("R8", "resync valid", 32'(out_valid), 1);
        check("R8", "resync tag", 32'(out_tag), 32'h5A);

        // R1 code 0x6
        drive(1'b1, 32'h60000000, 1'b1, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b1);
        check("R1", "code6 err", 32'(hdr_err), 1);

        // R7 opcode parity flipped
        drive(1'b1, 32'h70210001, 1'b1, 1'b0);
        drive(1'b1, 32'h0000AAAA, 1'b1, 1'b0);
        check("R7", "opc parity err", 32'(hdr_err), 1);
        check("R7", "payload dropped", 32'(out_valid), 0);
        drive(1'b0, '0, 1'b1, 1'b1);

        // R7 register parity flipped on the checked register format
        drive(1'b1, 32'h48001002, 1'b1, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b0);
        check("R7", "reg parity err", 32'(hdr_err), 1);
        drive(1'b0, '0, 1'b1, 1'b1);
        // R7 count parity flipped
        drive(1'b1, 32'h40001082, 1'b1, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b0);
        check("R7", "cnt parity err", 32'(hdr_err), 1);
        drive(1'b0, '0, 1'b1, 1'b1);

        // R10 backpressure on the final word
        drive(1'b1, 32'h00010123, 1'b1, 1'b0);
        drive(1'b1, 32'hAAAA0001, 1'b1, 1'b0);
        drive(1'b1, 32'hBBBB0002, 1'b0, 1'b0);
        check("R10", "stall ready", 32'(in_ready), 0);
        check("R10", "stall valid", 32'(out_valid), 1);
        check("R10", "stall no done", 32'(pkt_done), 0);
        drive(1'b1, 32'hBBBB0002, 1'b0, 1'b0);
        check("R10", "held idx", 32'(out_index), 1);
        drive(1'b1, 32'hBBBB0002, 1'b1, 1'b0);
        check("R10", "release done", 32'(pkt_done), 1);
        check("R10", "release tag", 32'(out_tag), 32'h124);
        drive(1'b1, 32'h80000000, 1'b1, 1'b0);
        check("R4", "nop after stall", 32'(out_valid), 0);
        check("R4", "nop no done", 32'(pkt_done), 0);

        drive(1'b0, '0, 1'b1, 1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule